// File: doc/BRIEF.md
# Stack Call and Return Sequencer

This block sits beside the execute stage of a small 8-bit CPU and carries out every operation that moves a return address, a register pair or the flag byte through the memory stack. The decoder hands it an operation code together with the current program counter, the instruction length, the flag byte, a branch target and a 16-bit register pair. The block owns the 16-bit stack pointer. It moves one byte per cycle over a byte-wide memory port, and it also uses that port to read the jump tables kept in low memory.

An operation starts with a one-cycle `start_i` while the block is idle. `busy_o` is high for exactly one cycle per byte moved. A single `done_o` cycle follows, and in that cycle the new program counter, stack pointer, flag byte and register pair are valid. These results then hold until the next operation starts. Memory reads are combinational: `mem_rdata_i` must return the byte at `mem_addr_o` in the same cycle.

Top module: `stk_seq`

## Requirements
- R1: Each stack write goes to SP-1 and leaves SP at that address. Each stack read comes from SP and leaves SP one higher. All pointer and address arithmetic wraps modulo 65536.
- R2: Far call (op_i=0) stores return address pc_i+ilen_i, high byte first at SP-1 and low byte at SP-2. It then loads pc_o with tgt_i and leaves SP lowered by 2, taking 2 busy cycles.
- R3: Windowed call (op_i=1) stacks the return address exactly as R2 does. It sets pc_o to 0800h OR (tgt_i AND 07FFh), so every target lands in 0800h..0FFFh.
- R4: Table call (op_i=2) stacks the return address as R2 does. It then reads the new PC low byte from TBL_BASE+2*tgt_i[4:0] and the high byte from the next address, taking 4 busy cycles.
- R5: Trap (op_i=3) writes the flag byte at SP-1, the return high byte at SP-2 and the return low byte at SP-3. It loads the PC from TRAP_VEC (low) and TRAP_VEC+1 (high), lowers SP by 3 and returns flags_o with bit 7 (interrupt enable) cleared, taking 5 busy cycles.
- R6: Subroutine return (op_i=4) reads the PC low byte from SP and the high byte from SP+1, and raises SP by 2.
- R7: Interrupt return (op_i=5) does what R6 does, then restores flags_o from SP+2 and raises SP by 3 in total. It pulses nmi_srv_clr_o together with done_o.
- R8: Trap return (op_i=6) behaves like R7 but never raises nmi_srv_clr_o.
- R9: Pair push (op_i=7) writes pair_i high at SP-1 and low at SP-2. Flag push (op_i=8) writes flags_i at SP-1. pc_o stays equal to pc_i for both.
- R10: Pair pop (op_i=9) returns pair_o as {byte at SP+1, byte at SP} and raises SP by 2. Flag pop (op_i=10) returns flags_o from SP and raises SP by 1.
- R11: After reset the block is idle with sp_o=SP_INIT. busy_o is high for one cycle per byte moved, and done_o is high for exactly one cycle after the last byte.
- R12: start_i is ignored while busy_o or done_o is high. Neither SP nor the results are altered by it.
- R13: Codes 11 to 15 move no byte. They reach done_o after zero busy cycles, with SP unchanged and pc_o and flags_o equal to the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_i | input | 4 | Operation code |
| pc_i | input | 16 | Address of the current instruction |
| ilen_i | input | 2 | Instruction length added to form the return address |
| flags_i | input | 8 | Current flag byte |
| tgt_i | input | 16 | Call target or table index |
| pair_i | input | 16 | Register pair to push |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_re_o | output | 1 | Memory byte read strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read, same cycle as the address |
| busy_o | output | 1 | A byte transfer runs this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | New program counter |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 8 | New flag byte |
| pair_o | output | 16 | Popped register pair |
| nmi_srv_clr_o | output | 1 | Clear the non-maskable in-service flag |

## Verification
The bench builds the block with SP_INIT=0004h and leaves the table base and trap vector at their defaults. With a stack that starts only four bytes above zero, a short run of nested calls and pushes carries the pointer across the 0000h/FFFFh boundary, and the pops and returns that follow bring it back. Around that, the bench sweeps all 32 table entries, every instruction length with a return address that wraps, window targets at both edges of the 11-bit field, and trap flag bytes with and without the enable bit. It also checks that start requests arriving mid-operation and during the completion cycle are dropped.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned AW   = 16;
  localparam int unsigned DW   = 8;
  localparam int unsigned OPW  = 4;
  localparam int unsigned MAXB = 5;
  localparam int unsigned KW   = $clog2(MAXB + 1);
  localparam int unsigned NB   = 4;
  localparam logic [AW-1:0] WIN_BASE = 16'h0800;
  localparam logic [AW-1:0] WIN_MASK = 16'h07FF;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] byte_t;

  typedef enum logic [OPW-1:0] {
    OP_CALL_FAR   = 4'd0,
    OP_CALL_WIN   = 4'd1,
    OP_CALL_TBL   = 4'd2,
    OP_TRAP       = 4'd3,
    OP_RET_SUB    = 4'd4,
    OP_RET_INT    = 4'd5,
    OP_RET_TRAP   = 4'd6,
    OP_PUSH_PAIR  = 4'd7,
    OP_PUSH_FLAGS = 4'd8,
    OP_POP_PAIR   = 4'd9,
    OP_POP_FLAGS  = 4'd10
  } op_e;

  typedef struct packed {
    logic [1:0] n_wr;
    logic [1:0] n_rd;
    logic       vec;   // reads come from a fixed table, not the stack
  } plan_t;

  function automatic plan_t op_plan(logic [OPW-1:0] op);
    plan_t p;
    p = '0;
    case (op_e'(op))
      OP_CALL_FAR, OP_CALL_WIN, OP_PUSH_PAIR: p.n_wr = 2'd2;
      OP_CALL_TBL:  begin p.n_wr = 2'd2; p.n_rd = 2'd2; p.vec = 1'b1; end
      OP_TRAP:      begin p.n_wr = 2'd3; p.n_rd = 2'd2; p.vec = 1'b1; end
      OP_RET_SUB, OP_POP_PAIR:  p.n_rd = 2'd2;
      OP_RET_INT, OP_RET_TRAP:  p.n_rd = 2'd3;
      OP_PUSH_FLAGS: p.n_wr = 2'd1;
      OP_POP_FLAGS:  p.n_rd = 2'd1;
      default: ;
    endcase
    return p;
  endfunction

  function automatic logic [KW-1:0] plan_len(plan_t p);
    return KW'(p.n_wr) + KW'(p.n_rd);
  endfunction
endpackage

// File: rtl/stk_step.sv
module stk_step
  import stk_pkg::*;
(
  input  plan_t              plan_i,
  input  logic [KW-1:0]      k_i,
  input  addr_t              wp_i,
  input  addr_t              vbase_i,
  input  logic [NB-1:0][DW-1:0] wb_i,
  output logic               we_o,
  output logic               re_o,
  output logic               rd_stk_o,
  output addr_t              addr_o,
  output byte_t              wdata_o,
  output logic               last_o,
  output logic [1:0]         ridx_o
);
  logic [KW-1:0] rd_full;

  // writes always precede reads within one operation
  assign we_o     = k_i < KW'(plan_i.n_wr);
  assign re_o     = !we_o;
  assign rd_stk_o = re_o && !plan_i.vec;
  assign rd_full  = k_i - KW'(plan_i.n_wr);
  assign ridx_o   = rd_full[1:0];
  assign wdata_o  = wb_i[k_i[1:0]];
  assign last_o   = (k_i == plan_len(plan_i) - KW'(1));

  always_comb begin
    if (we_o)            addr_o = wp_i - addr_t'(1);
    else if (plan_i.vec) addr_o = vbase_i + addr_t'(ridx_o);
    else                 addr_o = wp_i;
  end
endmodule

// File: rtl/stk_result.sv
module stk_result
  import stk_pkg::*;
#(
  parameter int unsigned IE_BIT = 7
) (
  input  logic [OPW-1:0]        op_i,
  input  addr_t                 pc_i,
  input  addr_t                 tgt_i,
  input  byte_t                 flags_i,
  input  logic [AW-1:0]         pair_i,
  input  logic [NB-1:0][DW-1:0] rb_i,
  output addr_t                 pc_o,
  output byte_t                 flags_o,
  output logic [AW-1:0]         pair_o
);
  always_comb begin
    pc_o    = pc_i;
    flags_o = flags_i;
    pair_o  = pair_i;
    case (op_e'(op_i))
      OP_CALL_FAR: pc_o = tgt_i;
      OP_CALL_WIN: pc_o = WIN_BASE | (tgt_i & WIN_MASK);
      OP_CALL_TBL, OP_RET_SUB: pc_o = {rb_i[1], rb_i[0]};
      OP_TRAP: begin
        pc_o = {rb_i[1], rb_i[0]};
        flags_o[IE_BIT] = 1'b0;
      end
      OP_RET_INT, OP_RET_TRAP: begin
        pc_o    = {rb_i[1], rb_i[0]};
        flags_o = rb_i[2];
      end
      OP_POP_PAIR:  pair_o  = {rb_i[1], rb_i[0]};
      OP_POP_FLAGS: flags_o = rb_i[0];
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter logic [15:0] SP_INIT  = 16'hFE00,
  parameter logic [15:0] TBL_BASE = 16'h0040,
  parameter logic [15:0] TRAP_VEC = 16'h003E,
  parameter int unsigned IE_BIT   = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [3:0]  op_i,
  input  logic [15:0] pc_i,
  input  logic [1:0]  ilen_i,
  input  logic [7:0]  flags_i,
  input  logic [15:0] tgt_i,
  input  logic [15:0] pair_i,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] pc_o,
  output logic [15:0] sp_o,
  output logic [7:0]  flags_o,
  output logic [15:0] pair_o,
  output logic        nmi_srv_clr_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

  st_e                   st;
  logic [KW-1:0]         k;
  addr_t                 sp_q, pc_q, tgt_q, vbase_q, vbase_d, ret_in;
  logic [OPW-1:0]        op_q;
  byte_t                 flags_q;
  logic [AW-1:0]         pair_q;
  logic [NB-1:0][DW-1:0] wb_q, wb_d, rb_q;
  plan_t                 plan_in, plan_q;

  logic       step_we, step_re, step_rd_stk, step_last;
  addr_t      step_addr;
  byte_t      step_wdata;
  logic [1:0] step_ridx;

  always_comb begin
    plan_in = op_plan(op_i);
    plan_q  = op_plan(op_q);
    ret_in  = pc_i + addr_t'(ilen_i);
    wb_d    = '0;
    case (op_e'(op_i))
      OP_CALL_FAR, OP_CALL_WIN, OP_CALL_TBL: begin
        wb_d[0] = ret_in[AW-1:DW];
        wb_d[1] = ret_in[DW-1:0];
      end
      OP_TRAP: begin
        wb_d[0] = flags_i;
        wb_d[1] = ret_in[AW-1:DW];
        wb_d[2] = ret_in[DW-1:0];
      end
      OP_PUSH_PAIR: begin
        wb_d[0] = pair_i[AW-1:DW];
        wb_d[1] = pair_i[DW-1:0];
      end
      OP_PUSH_FLAGS: wb_d[0] = flags_i;
      default: ;
    endcase
    vbase_d = (op_e'(op_i) == OP_CALL_TBL) ? TBL_BASE + addr_t'({tgt_i[4:0], 1'b0})
                                            : TRAP_VEC;
  end

  stk_step u_step (
    .plan_i   (plan_q),
    .k_i      (k),
    .wp_i     (sp_q),
    .vbase_i  (vbase_q),
    .wb_i     (wb_q),
    .we_o     (step_we),
    .re_o     (step_re),
    .rd_stk_o (step_rd_stk),
    .addr_o   (step_addr),
    .wdata_o  (step_wdata),
    .last_o   (step_last),
    .ridx_o   (step_ridx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      k       <= '0;
      sp_q    <= SP_INIT;
      op_q    <= '0;
      pc_q    <= '0;
      tgt_q   <= '0;
      flags_q <= '0;
      pair_q  <= '0;
      vbase_q <= '0;
      wb_q    <= '0;
      rb_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_i) begin
          op_q    <= op_i;
          pc_q    <= pc_i;
          tgt_q   <= tgt_i;
          flags_q <= flags_i;
          pair_q  <= pair_i;
          vbase_q <= vbase_d;
          wb_q    <= wb_d;
          k       <= '0;
          st      <= (plan_len(plan_in) == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (step_we)          sp_q <= sp_q - addr_t'(1);
          else if (step_rd_stk) sp_q <= sp_q + addr_t'(1);
          if (step_re) rb_q[step_ridx] <= mem_rdata_i;
          k <= k + KW'(1);
          if (step_last) st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (st == ST_RUN);
  assign done_o        = (st == ST_DONE);
  assign mem_we_o      = busy_o && step_we;
  assign mem_re_o      = busy_o && step_re;
  assign mem_addr_o    = step_addr;
  assign mem_wdata_o   = step_wdata;
  assign sp_o          = sp_q;
  assign nmi_srv_clr_o = done_o && (op_e'(op_q) == OP_RET_INT);

  stk_result #(.IE_BIT(IE_BIT)) u_res (
    .op_i    (op_q),
    .pc_i    (pc_q),
    .tgt_i   (tgt_q),
    .flags_i (flags_q),
    .pair_i  (pair_q),
    .rb_i    (rb_q),
    .pc_o    (pc_o),
    .flags_o (flags_o),
    .pair_o  (pair_o)
  );

  // R1
  sp_pre_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(mem_addr_o));
  // R1
  sp_post_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && step_rd_stk) |=> sp_o == $past(mem_addr_o) + 16'd1);
  // R1
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  // R11
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  sp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(sp_o));
  // R7
  nmi_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_srv_clr_o |-> done_o);
  // R12
  ign_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || done_o) |=> $stable(op_q));
endmodule

// File: tb/sim_stk_seq.sv
module sim_stk_seq;
  import stk_pkg::*;
  localparam logic [15:0] SP0 = 16'h0004;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] pc_i = '0, tgt_i = '0, pair_i = '0;
  logic [1:0]  ilen_i = '0;
  logic [7:0]  flags_i = '0;
  logic        mem_we_o, mem_re_o, busy_o, done_o, nmi_srv_clr_o;
  logic [15:0] mem_addr_o, pc_o, sp_o, pair_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, flags_o;

  logic [7:0] mem [0:65535];
  assign mem_rdata_i = mem[mem_addr_o];

  always #10 clk_i = ~clk_i;

  stk_seq #(.SP_INIT(SP0)) u0 (.*);

  int n_chk = 0, n_err = 0, busy_n = 0, wr_n = 0;
  logic [15:0] sp_m;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    if (mem_we_o) begin
      mem[mem_addr_o] = mem_wdata_o;
      wr_n++;
    end
    @(negedge clk_i);
  endtask

  task automatic run_op(input logic [3:0] op, input logic [15:0] pc, input logic [1:0] il,
                        input logic [7:0] fl, input logic [15:0] tg, input logic [15:0] pr);
    @(negedge clk_i);
    chk("R11 done lasts one cycle", done_o, 0);
    op_i = op; pc_i = pc; ilen_i = il; flags_i = fl; tgt_i = tg; pair_i = pr; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; busy_n = 0; wr_n = 0;
    while (!done_o) begin
      if (busy_o) busy_n++;
      tick();
    end
  endtask

  task automatic call_ret(input logic [3:0] op, input logic [15:0] pc, input logic [1:0] il,
                          input logic [15:0] tg, input logic [15:0] exp_pc, input int exp_busy,
                          input string tag);
    logic [15:0] ret, a1, a2;
    ret = pc + 16'(il); a1 = sp_m - 16'd1; a2 = sp_m - 16'd2;
    run_op(op, pc, il, 8'h00, tg, 16'h0);
    chk({tag, " ret high byte"}, mem[a1], ret[15:8]);
    chk({tag, " ret low byte"}, mem[a2], ret[7:0]);
    chk({tag, " pc"}, pc_o, exp_pc);
    chk({tag, " sp"}, sp_o, a2);
    chk({tag, " busy cycles"}, busy_n, exp_busy);
    sp_m = a2;
    run_op(OP_RET_SUB, 16'h0, 2'd0, 8'h00, 16'h0, 16'h0);
    chk("R6 return pc", pc_o, ret);
    chk("R6 return sp", sp_o, sp_m + 16'd2);
    chk("R6 busy cycles", busy_n, 2);
    sp_m = sp_m + 16'd2;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] tg, ret, a;
    logic [7:0]  fl;
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    for (int n = 0; n < 32; n++) begin
      mem[16'h0040 + 16'(2*n)] = 8'(n * 5);
      mem[16'h0041 + 16'(2*n)] = 8'hC0 | 8'(n);
    end
    mem[16'h003E] = 8'hCD;
    mem[16'h003F] = 8'hAB;

    repeat (3) @(negedge clk_i);
    chk("R11 reset busy", busy_o, 0);
    chk("R11 reset done", done_o, 0);
    chk("R11 reset sp", sp_o, SP0);
    rst_ni = 1'b1;
    sp_m = SP0;

    // R2 far calls, all lengths, wrapping return address
    for (int il = 1; il <= 3; il++)
      for (int pi = 0; pi < 2; pi++) begin
        tg = 16'hA55A ^ 16'(il);
        call_ret(OP_CALL_FAR, pi ? 16'hFFFE : 16'h1234, 2'(il), tg, tg, 2, "R2");
      end

    // R3 window calls
    for (int i = 0; i < 6; i++) begin
      tg = (i == 0) ? 16'h0000 : (i == 1) ? 16'h07FF : (i == 2) ? 16'hFFFF : 16'(16'h3C5A * i);
      call_ret(OP_CALL_WIN, 16'h4000 + 16'(i), 2'd2, tg, 16'h0800 | (tg & 16'h07FF), 2, "R3");
    end

    // R4 every table entry
    for (int n = 0; n < 32; n++)
      call_ret(OP_CALL_TBL, 16'h5000 + 16'(n), 2'd1, 16'hFFE0 | 16'(n),
               {8'hC0 | 8'(n), 8'(n * 5)}, 4, "R4");

    // R5 trap then R7/R8 returns
    for (int i = 0; i < 4; i++) begin
      fl  = (i == 0) ? 8'h80 : (i == 1) ? 8'hFF : (i == 2) ? 8'h00 : 8'h7F;
      ret = 16'h2000 + 16'(i) + 16'd1;
      run_op(OP_TRAP, 16'h2000 + 16'(i), 2'd1, fl, 16'h0, 16'h0);
      a = sp_m - 16'd1; chk("R5 flags stacked", mem[a], fl);
      a = sp_m - 16'd2; chk("R5 ret high", mem[a], ret[15:8]);
      a = sp_m - 16'd3; chk("R5 ret low", mem[a], ret[7:0]);
      chk("R5 pc from vector", pc_o, 16'hABCD);
      chk("R5 enable cleared", flags_o, fl & 8'h7F);
      chk("R5 sp", sp_o, sp_m - 16'd3);
      chk("R5 busy cycles", busy_n, 5);
      chk("R8 no clear on trap", nmi_srv_clr_o, 0);
      sp_m = sp_m - 16'd3;
      run_op(i[0] ? OP_RET_INT : OP_RET_TRAP, 16'h0, 2'd0, 8'h00, 16'h0, 16'h0);
      chk("R7 R8 return pc", pc_o, ret);
      chk("R7 R8 flags restored", flags_o, fl);
      chk("R7 R8 sp", sp_o, sp_m + 16'd3);
      chk("R7 R8 busy cycles", busy_n, 3);
      chk(i[0] ? "R7 nmi clear" : "R8 nmi kept", nmi_srv_clr_o, i[0]);
      sp_m = sp_m + 16'd3;
    end

    // R1 wrap with R9/R10 push and pop
    run_op(OP_CALL_FAR, 16'h0100, 2'd3, 8'h0, 16'h0200, 16'h0); sp_m = sp_m - 16'd2;
    run_op(OP_CALL_FAR, 16'h0300, 2'd3, 8'h0, 16'h0400, 16'h0); sp_m = sp_m - 16'd2;
    chk("R1 sp at zero", sp_o, 16'h0000);
    run_op(OP_PUSH_PAIR, 16'h7777, 2'd1, 8'h0, 16'h0, 16'hBEEF);
    chk("R1 R9 wrap high", mem[16'hFFFF], 8'hBE);
    chk("R1 R9 wrap low", mem[16'hFFFE], 8'hEF);
    chk("R1 R9 sp wraps", sp_o, 16'hFFFE);
    chk("R9 pc kept", pc_o, 16'h7777);
    run_op(OP_PUSH_FLAGS, 16'h7778, 2'd1, 8'h5A, 16'h0, 16'h0);
    chk("R9 flags byte", mem[16'hFFFD], 8'h5A);
    chk("R9 flag push sp", sp_o, 16'hFFFD);
    chk("R9 flag push busy", busy_n, 1);
    run_op(OP_POP_FLAGS, 16'h0, 2'd0, 8'h00, 16'h0, 16'h0);
    chk("R10 flags popped", flags_o, 8'h5A);
    chk("R10 flag pop sp", sp_o, 16'hFFFE);
    run_op(OP_POP_PAIR, 16'h0, 2'd0, 8'h00, 16'h0, 16'h0);
    chk("R10 pair popped", pair_o, 16'hBEEF);
    chk("R1 R10 sp wraps back", sp_o, 16'h0000);
    run_op(OP_RET_SUB, 16'h0, 2'd0, 8'h0, 16'h0, 16'h0);
    chk("R6 nested return", pc_o, 16'h0303);
    run_op(OP_RET_SUB, 16'h0, 2'd0, 8'h0, 16'h0, 16'h0);
    chk("R6 outer return", pc_o, 16'h0103);
    sp_m = sp_m + 16'd4;
    chk("R1 sp restored", sp_o, SP0);

    // R12 start during busy and during done
    @(negedge clk_i);
    op_i = OP_CALL_TBL; pc_i = 16'h3000; ilen_i = 2'd1; tgt_i = 16'h0003; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; tick();
    op_i = OP_PUSH_FLAGS; start_i = 1'b1; tick(); start_i = 1'b0;
    while (!done_o) tick();
    start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk("R12 start in done ignored", busy_o, 0);
    chk("R12 sp unaffected", sp_o, SP0 - 16'd2);
    chk("R12 pc unaffected", pc_o, {8'hC3, 8'd15});
    run_op(OP_RET_SUB, 16'h0, 2'd0, 8'h0, 16'h0, 16'h0);
    chk("R12 return after ignored start", pc_o, 16'h3001);

    // R13 unused codes
    for (int c = 11; c < 16; c++) begin
      run_op(4'(c), 16'h6000 + 16'(c), 2'd3, 8'h3C, 16'h1111, 16'h2222);
      chk("R13 no busy", busy_n, 0);
      chk("R13 no write", wr_n, 0);
      chk("R13 sp kept", sp_o, SP0);
      chk("R13 pc kept", pc_o, 16'h6000 + 16'(c));
      chk("R13 flags kept", flags_o, 8'h3C);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule